// File: doc/BRIEF.md
# Sensor Slave-Mode Sync Generator

This block produces the vertical and horizontal readout strobes that an image sensor expects when it is configured as a timing slave. It runs on the very clock that is fed to the sensor, so every strobe edge keeps a fixed phase to the sensor's own sampling. Three 12-bit counts set the timing, all measured in sensor input-clock cycles: the number of clocks per line, the number of lines per frame, and the width of the active-low pulse that both strobes share.

A mode input chooses who owns the strobe wires. When the sensor generates its own timing, the block releases both strobes by clearing their output enables. When the sensor is a slave, the block drives both strobes. The horizontal strobe then pulses once per line, and the vertical strobe pulses once per frame, with its falling edge on the same clock as a horizontal falling edge. Each strobe and its enable come out as plain outputs, and a pad buffer outside the block forms the tri-state pin.

Top module: `sensor_sync_gen`

## Requirements
- R1: While `slave_en` is 0, both `hsync_oe` and `vsync_oe` are 0 and both `hsync_n` and `vsync_n` sit at 1, from the first clock edge that samples `slave_en` = 0.
- R2: While `slave_en` is 1 and reset is released, both `hsync_oe` and `vsync_oe` are 1 from the first clock edge that samples `slave_en` = 1.
- R3: In slave mode with `line_len` = H > 0 and `pulse_len` = W, number the clock edges from 0, starting at the first edge after the timing starts. After edge k, `hsync_n` is 0 exactly when (k mod H) < W, so XHS repeats every H clocks.
- R4: In slave mode with `line_len` = H > 0 and `frame_lines` = V > 0, after edge k `vsync_n` is 0 exactly when ((k div H) mod V) = 0 and (k mod H) < W. XVS therefore repeats every V lines and falls on the same clock as an XHS falling edge.
- R5: While `rst_n` is 0, both enables are 0 and both strobes are 1. On the first clock edge after `rst_n` rises, with slave mode, nonzero totals and W > 0, both strobes go to 0 together.
- R6: A `line_len` of 0 holds both strobes at 1. A `frame_lines` of 0 holds `vsync_n` at 1 while `hsync_n` keeps running. In both cases the enables still follow R2.
- R7: A `pulse_len` of 0 produces no pulse on either strobe. A `pulse_len` of H or more holds `hsync_n` at 0 for every clock, and `vsync_n` at 0 for the whole of the first line of each frame.
- R8: A change from master to slave without a reset restarts the timing: the first edge that samples `slave_en` = 1 is edge 0 of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor input clock, shared with the sensor |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | 1: block drives the strobes; 0: strobes released |
| line_len | input | 12 | Clocks per line (H); 0 disables both strobes |
| frame_lines | input | 12 | Lines per frame (V); 0 disables the vertical strobe |
| pulse_len | input | 12 | Low time of each strobe in clocks (W) |
| hsync_n | output | 1 | Horizontal strobe, active low |
| hsync_oe | output | 1 | Output enable for the horizontal strobe |
| vsync_n | output | 1 | Vertical strobe, active low |
| vsync_oe | output | 1 | Output enable for the vertical strobe |

## Verification
On a frame boundary the line counter wrap and the frame counter wrap land on the same clock, and both strobes must fall on the next edge. Short lines and short frames (H = 6, V = 3) make this coincidence frequent. Every cycle of the output is compared with a model that computes line and position from the edge count by division, not by counting. A second case where two events meet is a mode change back to slave in the middle of a line: the restart must override the running position, and the bench checks that the first strobe pair comes out on the first slave edge.

// File: rtl/sensor_sync_pkg.sv
package sensor_sync_pkg;
  localparam int unsigned CNT_W = 12;
  typedef logic [CNT_W-1:0] cnt_t;

  // Last position of a period; a zero total has no last position.
  function automatic logic period_last(input cnt_t cnt, input cnt_t total);
    return (total != '0) && (cnt >= total - cnt_t'(1));
  endfunction

  // Strobe is low while the position lies inside the pulse window.
  function automatic logic in_window(input cnt_t cnt, input cnt_t width);
    return cnt < width;
  endfunction
endpackage

// File: rtl/ss_period_cnt.sv
module ss_period_cnt
  import sensor_sync_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  assign last = (total != '0) && (cnt >= total - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr || total == '0)   cnt <= '0;
    else if (step)                 cnt <= last ? '0 : cnt + ONE;
  end

  // R3: a wrap always returns the position to zero
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (cnt == '0));

  // R3: with a steady total the position stays inside the period
  assert_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (total != '0 && cnt < total && $stable(total)) |=> (cnt < total || total != $past(total)));
endmodule

// File: rtl/ss_sync_drive.sv
module ss_sync_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic fire,
  output logic sync_n,
  output logic sync_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_n  <= 1'b1;
      sync_oe <= 1'b0;
    end else begin
      sync_oe <= drive;
      sync_n  <= !(drive && fire);
    end
  end

  // R1: a released strobe always idles high
  assert_release_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe |-> sync_n);
endmodule

// File: rtl/sensor_sync_gen.sv
module sensor_sync_gen
  import sensor_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_en,
  input  logic [CNT_W-1:0] line_len,
  input  logic [CNT_W-1:0] frame_lines,
  input  logic [CNT_W-1:0] pulse_len,
  output logic             hsync_n,
  output logic             hsync_oe,
  output logic             vsync_n,
  output logic             vsync_oe
);
  cnt_t h_pos, v_line;
  logic h_last, v_last;
  logic h_run, v_run;
  logic hs_fire, vs_fire;

  assign h_run = slave_en && (line_len != '0);
  assign v_run = h_run && (frame_lines != '0);

  ss_period_cnt #(.W(CNT_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(!slave_en), .step(1'b1),
    .total(line_len), .cnt(h_pos), .last(h_last)
  );

  ss_period_cnt #(.W(CNT_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(!h_run), .step(h_last),
    .total(frame_lines), .cnt(v_line), .last(v_last)
  );

  // Named events for the checks below
  assign hs_fire = h_run && in_window(h_pos, pulse_len);
  assign vs_fire = v_run && (v_line == '0) && hs_fire;

  ss_sync_drive u_hdrv (
    .clk(clk), .rst_n(rst_n), .drive(slave_en), .fire(hs_fire),
    .sync_n(hsync_n), .sync_oe(hsync_oe)
  );

  ss_sync_drive u_vdrv (
    .clk(clk), .rst_n(rst_n), .drive(slave_en), .fire(vs_fire),
    .sync_n(vsync_n), .sync_oe(vsync_oe)
  );

  // R4: a vertical pulse is always inside a horizontal pulse
  assert_vs_in_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !hsync_n);

  // R1: master mode releases both strobes on the next edge
  assert_master_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |=> (!hsync_oe && !vsync_oe));

  // R2: slave mode enables both strobes on the next edge
  assert_slave_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slave_en |=> (hsync_oe && vsync_oe));

  // R6: zero line length keeps both strobes idle
  assert_zero_line_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_len == '0) |=> (hsync_n && vsync_n));

  // R6: zero frame length keeps the vertical strobe idle
  assert_zero_frame_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_lines == '0) |=> vsync_n);

  // R4: the frame counter only advances at a line wrap
  assert_line_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_run && !h_last && $stable(frame_lines)) |=> $stable(v_line));

  logic unused_v_last;
  assign unused_v_last = v_last;
endmodule

// File: tb/sensor_sync_gen_tb.sv
module sensor_sync_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_en = 1'b0;
  logic [11:0] line_len = '0, frame_lines = '0, pulse_len = '0;
  logic hsync_n, hsync_oe, vsync_n, vsync_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic  hs, vs, hoe, voe;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  sensor_sync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en),
    .line_len(line_len), .frame_lines(frame_lines), .pulse_len(pulse_len),
    .hsync_n(hsync_n), .hsync_oe(hsync_oe), .vsync_n(vsync_n), .vsync_oe(vsync_oe)
  );

  function automatic exp_t model(input logic sl, input int h, input int v,
                                 input int w, input int k, input string tag);
    exp_t e;
    int pos, line;
    e.tag = tag;
    e.hoe = sl;
    e.voe = sl;
    e.hs = 1'b1;
    e.vs = 1'b1;
    if (sl && h != 0) begin
      pos = k % h;
      e.hs = !(pos < w);
      if (v != 0) begin
        line = (k / h) % v;
        e.vs = !((line == 0) && (pos < w));
      end
    end
    return e;
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (hsync_n !== e.hs || vsync_n !== e.vs || hsync_oe !== e.hoe || vsync_oe !== e.voe) begin
      errors++;
      $display("FAIL %s: actual hs=%b vs=%b hoe=%b voe=%b expected hs=%b vs=%b hoe=%b voe=%b",
               e.tag, hsync_n, vsync_n, hsync_oe, vsync_oe, e.hs, e.vs, e.hoe, e.voe);
    end
  endtask

  // Monitor: pops one expected item per edge, sampled at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) compare(sb.pop_front());
  end

  // Driver: applies a configuration and pushes the expected output per edge
  task automatic run_cfg(input bit do_reset, input logic sl, input int h, input int v,
                         input int w, input int n, input string tag);
    exp_t r;
    @(negedge clk); #1;
    if (do_reset) begin
      rst_n = 1'b0;
      slave_en = sl;
      line_len = 12'(h);
      frame_lines = 12'(v);
      pulse_len = 12'(w);
      @(negedge clk);
      r.hs = 1'b1; r.vs = 1'b1; r.hoe = 1'b0; r.voe = 1'b0; r.tag = "R5 reset state";
      compare(r);
      #1 rst_n = 1'b1;
    end else begin
      slave_en = sl;
      line_len = 12'(h);
      frame_lines = 12'(v);
      pulse_len = 12'(w);
    end
    for (int k = 0; k < n; k++) begin
      sb.push_back(model(sl, h, v, w, k, tag));
      @(posedge clk);
    end
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run_cfg(1, 1'b1, 6, 3, 2, 60, "R3 R4 R5 basic slave");
    run_cfg(1, 1'b1, 100, 4, 10, 500, "R3 R4 long line");
    run_cfg(1, 1'b1, 5, 2, 0, 30, "R7 zero width");
    run_cfg(1, 1'b1, 4, 3, 7, 30, "R7 wide pulse");
    run_cfg(1, 1'b1, 0, 3, 2, 20, "R6 zero line length");
    run_cfg(1, 1'b1, 5, 0, 2, 30, "R6 zero frame length");
    run_cfg(1, 1'b0, 6, 3, 2, 20, "R1 master after reset");
    run_cfg(1, 1'b1, 7, 2, 3, 17, "R2 slave before switch");
    run_cfg(0, 1'b0, 7, 2, 3, 9, "R1 switch to master");
    run_cfg(0, 1'b1, 7, 2, 3, 40, "R8 restart from master");
    run_cfg(1, 1'b1, 1, 2, 1, 10, "R7 one clock line");
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual cycles %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule